// File: doc/BRIEF.md
# Quarter-Wave Sine Tone Synthesizer

This block is a direct digital synthesis tone source for an audio note player. A 22-bit phase register moves forward by a 12.10 fixed-point step each time the sample-rate strobe arrives. One sine period is 4096 integer phase units. The block keeps only one quadrant of the wave in a table of 1024 constants, which it computes itself at elaboration. It uses the two top phase bits to reflect the table address and to flip the sign. The result is a signed 16-bit sample and a one-cycle valid flag.

The input side is a valid-only stream. `step_valid` is a one-cycle request, and it always carries the `phase_inc` value present in that same cycle. The block has no ready output. It accepts a request on every cycle, including back-to-back cycles, and its pipeline never stalls.

The output side is also a valid-only stream. There is no back-pressure. A consumer must take `smp_data` in the cycle where `smp_valid` is high. Between two valid cycles the last sample stays on `smp_data`.

For a strobe rate Fs, an increment of f·4096/Fs, written in 12.10 format, produces a tone of frequency f. A zero increment is a rest note: each strobe repeats the previous sample.

Top module: `sine_dds`

## Requirements
- R1: A synchronous active-high reset clears the phase to 0, drives `smp_data` to 0 and `smp_valid` to 0, and discards requests in flight. Strobes seen while reset is high are ignored. After reset, the first sample is therefore taken at phase `phase_inc`.
- R2: Each accepted strobe adds `phase_inc` to the phase modulo 2^22, before the lookup. Bits [21:10] of the increment are the integer part and bits [9:0] are the fraction. Sample n after reset is taken at phase (sum of the first n increments) mod 2^22.
- R3: Quarter-table entry i, for i from 0 to 1023, equals round(32767·sin(2π·i/4096)). In quadrant 0 (phase[21:20] = 0), the sample is the entry at address phase[19:10].
- R4: In quadrants 1 and 3 (phase[20] = 1), the table address is the bitwise complement of phase[19:10], which equals 1023 minus that field.
- R5: In quadrants 2 and 3 (phase[21] = 1), the sample is the two's-complement negation of the table entry.
- R6: `smp_valid` is high for exactly one cycle, in the third cycle after each strobe. That is the cycle after the third rising edge, counting the edge that samples the strobe. Strobes on consecutive cycles each produce their own valid cycle.
- R7: `smp_data` changes only in a cycle where `smp_valid` is high. Otherwise it holds its value.
- R8: A strobe with `phase_inc` = 0 produces a valid sample equal to the previous sample.
- R9: `smp_data` never takes the value -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| phase_inc | input | 22 | Phase step, 12.10 fixed point, sampled with the strobe |
| step_valid | input | 1 | One-cycle sample-rate strobe (input valid) |
| smp_data | output | 16 | Signed sample, held between valid cycles |
| smp_valid | output | 1 | One-cycle flag marking a new sample |

## Verification
The checker watches four behaviours on every cycle. It confirms that the valid flag follows each strobe by exactly three cycles. It confirms that the sample never moves outside a valid cycle. It confirms that a zero-step strobe repeats the previous sample. It confirms that the most negative code never appears. The numeric content of each sample can only be shown by the bench scenarios. These are: a unit-step sweep that visits every table address in all four quadrants, a fractional step, a step that wraps downward every cycle, a stream of pseudo-random steps, and resets applied while requests are in flight. The bench compares each of these against samples computed with the real sine function.

// File: rtl/sdds_pkg.sv
package sdds_pkg;

  // Quadrant of the phase, taken from its two most significant bits.
  typedef enum logic [1:0] {
    QD_RISE     = 2'd0,
    QD_FALL     = 2'd1,
    QD_NEG_FALL = 2'd2,
    QD_NEG_RISE = 2'd3
  } quad_e;

  // Odd quadrants read the table backwards.
  function automatic logic quad_mirrors(quad_e q);
    return (q == QD_FALL) || (q == QD_NEG_RISE);
  endfunction

  // The second half-period is negative.
  function automatic logic quad_negates(quad_e q);
    return (q == QD_NEG_FALL) || (q == QD_NEG_RISE);
  endfunction

  // Rounded amp*sin(2*pi*idx/cycle_pts), from a Taylor series.
  // The argument stays inside the first quadrant.
  function automatic int quarter_sine(int idx, int cycle_pts, int amp);
    real x;
    real term;
    real acc;
    x    = 2.0 * 3.14159265358979 * idx / cycle_pts;
    term = x;
    acc  = x;
    for (int k = 1; k < 14; k++) begin
      term = -term * x * x / ((2.0 * k) * (2.0 * k + 1.0));
      acc  = acc + term;
    end
    return $rtoi(acc * amp + 0.5);
  endfunction

endpackage

// File: rtl/sdds_phase_acc.sv
module sdds_phase_acc #(
  parameter int PHASE_W = 22
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic [PHASE_W-1:0] inc,
  output logic [PHASE_W-1:0] phase,
  output logic               phase_vld
);

  // The phase wraps naturally at 2^PHASE_W.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      phase_vld <= 1'b0;
    end else begin
      phase_vld <= step;
      if (step) phase <= phase + inc;
    end
  end

endmodule

// File: rtl/sdds_quarter_rom.sv
module sdds_quarter_rom #(
  parameter int AW   = 10,
  parameter int DW   = 16,
  parameter int AMPL = 32767
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH     = 1 << AW;
  localparam int CYCLE_PTS = 4 * DEPTH;

  logic [DW-1:0] tbl [DEPTH];

  // Constants are computed at elaboration, one per address.
  for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
    localparam int VAL = sdds_pkg::quarter_sine(i, CYCLE_PTS, AMPL);
    assign tbl[i] = DW'(VAL);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= tbl[rd_addr];
  end

endmodule

// File: rtl/sdds_sign_stage.sv
module sdds_sign_stage #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic                 neg,
  input  logic        [DW-1:0] mag,
  output logic signed [DW-1:0] smp,
  output logic                 smp_vld
);

  logic signed [DW-1:0] mag_s;
  assign mag_s = $signed(mag);

  always_ff @(posedge clk) begin
    if (rst) begin
      smp     <= '0;
      smp_vld <= 1'b0;
    end else begin
      smp_vld <= in_vld;
      if (in_vld) smp <= neg ? -mag_s : mag_s;
    end
  end

endmodule

// File: rtl/sine_dds.sv
module sine_dds #(
  parameter int PHASE_W = 22,
  parameter int FRAC_W  = 10,
  parameter int QTR_AW  = 10,
  parameter int SMP_W   = 16,
  parameter int AMPL    = 32767
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PHASE_W-1:0]      phase_inc,
  input  logic                    step_valid,
  output logic signed [SMP_W-1:0] smp_data,
  output logic                    smp_valid
);
  import sdds_pkg::*;

  // The integer part of the phase must be exactly QTR_AW + 2 bits wide.
  localparam int QUAD_LSB = FRAC_W + QTR_AW;

  // Stage 1: phase register.
  logic [PHASE_W-1:0] phase;
  logic               phase_vld;

  sdds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .step      (step_valid),
    .inc       (phase_inc),
    .phase     (phase),
    .phase_vld (phase_vld)
  );

  // Quadrant fold.
  quad_e              quad;
  logic [QTR_AW-1:0]  raw_addr;
  logic [QTR_AW-1:0]  rd_addr;
  logic               unused_frac;

  assign quad        = quad_e'(phase[QUAD_LSB +: 2]);
  assign raw_addr    = phase[FRAC_W +: QTR_AW];
  assign rd_addr     = quad_mirrors(quad) ? ~raw_addr : raw_addr;
  assign unused_frac = ^phase[FRAC_W-1:0];

  // Stage 2: table read, with the sign and valid carried alongside.
  logic [SMP_W-1:0] mag;
  logic             neg_q;
  logic             rom_vld;

  sdds_quarter_rom #(.AW(QTR_AW), .DW(SMP_W), .AMPL(AMPL)) u_rom (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (phase_vld),
    .rd_addr (rd_addr),
    .rd_data (mag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q   <= 1'b0;
      rom_vld <= 1'b0;
    end else begin
      rom_vld <= phase_vld;
      if (phase_vld) neg_q <= quad_negates(quad);
    end
  end

  // Stage 3: sign and output register.
  sdds_sign_stage #(.DW(SMP_W)) u_sign (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (rom_vld),
    .neg     (neg_q),
    .mag     (mag),
    .smp     (smp_data),
    .smp_vld (smp_valid)
  );

endmodule

// File: rtl/sdds_checker.sv
module sdds_checker #(
  parameter int PHASE_W = 22,
  parameter int SMP_W   = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic [PHASE_W-1:0]      phase_inc,
  input logic                    step_valid,
  input logic signed [SMP_W-1:0] smp_data,
  input logic                    smp_valid
);

  // Saturating count of rising edges since reset, up to the pipeline depth.
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd3) |-> !smp_valid);

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (smp_valid == $past(step_valid, 3)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !smp_valid) |-> $stable(smp_data));

  assert_rest_repeat_R8: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && smp_valid && $past(phase_inc, 3) == '0)
      |-> (smp_data == $past(smp_data)));

  assert_no_min_code_R9: assert property (@(posedge clk) disable iff (rst)
    smp_data != {1'b1, {(SMP_W-1){1'b0}}});

endmodule

bind sine_dds sdds_checker #(.PHASE_W(PHASE_W), .SMP_W(SMP_W)) u_sdds_checker (
  .clk        (clk),
  .rst        (rst),
  .phase_inc  (phase_inc),
  .step_valid (step_valid),
  .smp_data   (smp_data),
  .smp_valid  (smp_valid)
);

// File: tb/test_sine_dds.sv
`timescale 1ns / 1ps
module test_sine_dds;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               step = 1'b0;
  logic [21:0]        inc = '0;
  logic signed [15:0] smp;
  logic               sv;

  always #10 clk = ~clk;

  sine_dds i_sine_dds (
    .clk        (clk),
    .rst        (rst),
    .phase_inc  (inc),
    .step_valid (step),
    .smp_data   (smp),
    .smp_valid  (sv)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Reference model state.
  logic [21:0] mphase = '0;
  bit          pv [3];
  int          pd [3];
  string       pt [3];
  int          last_d = 0;

  // Expected sample, computed from R2 to R5 with the real sine function.
  function automatic int ref_sample(logic [21:0] ph);
    int q;
    int r;
    int a;
    int m;
    q = int'(ph[21:20]);
    r = int'(ph[19:10]);
    a = q[0] ? (1023 - r) : r;
    m = $rtoi(32767.0 * $sin(2.0 * 3.14159265358979 * a / 4096.0) + 0.5);
    return q[1] ? -m : m;
  endfunction

  function automatic string tag_for(logic [21:0] ph, logic [21:0] k);
    if (k == '0)          return "R8";
    if (ph[21:20] == 2'd0) return "R3";
    if (ph[21:20] == 2'd1) return "R4";
    return "R5";
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive inputs, update the model at the edge, check at the falling edge.
  task automatic cyc(bit s, logic [21:0] k);
    step = s;
    inc  = k;
    @(posedge clk);
    if (rst) begin
      mphase = '0;
      last_d = 0;
      for (int j = 0; j < 3; j++) pv[j] = 1'b0;
    end else begin
      pv[2] = pv[1]; pd[2] = pd[1]; pt[2] = pt[1];
      pv[1] = pv[0]; pd[1] = pd[0]; pt[1] = pt[0];
      if (s) mphase = mphase + k;
      pv[0] = s;
      pd[0] = ref_sample(mphase);
      pt[0] = tag_for(mphase, k);
    end
    @(negedge clk);
    chk("R6", int'(sv), int'(pv[2]));
    if (pv[2]) begin
      last_d = pd[2];
      chk(pt[2], int'(smp), last_d);
    end else begin
      chk("R7", int'(smp), last_d);
    end
  endtask

  initial begin
    for (int j = 0; j < 3; j++) begin pv[j] = 1'b0; pd[j] = 0; pt[j] = ""; end
    @(negedge clk);
    repeat (3) cyc(1'b0, '0);
    // R1: a strobe while reset is high is ignored.
    cyc(1'b1, 22'h15555);
    chk("R1", int'(smp), 0);
    chk("R1", int'(sv), 0);
    rst = 1'b0;
    cyc(1'b0, '0);

    // R3 R4 R5: a unit integer step visits every address in every quadrant.
    for (int i = 0; i < 4096; i++) begin
      cyc(1'b1, 22'd1024);
      if (i % 3 == 0) cyc(1'b0, '0);
    end
    repeat (3) cyc(1'b0, '0);
    chk("R2", int'(smp), 0);  // 4096 unit steps wrap back to phase 0

    // R2: fractional step 58 + 360/1024.
    for (int i = 0; i < 600; i++) begin
      cyc(1'b1, {12'd58, 10'd360});
      cyc(1'b0, '0);
      cyc(1'b0, '0);
    end

    // R2 R6: a step of 2^22-1 wraps downward, with strobes on every cycle.
    for (int i = 0; i < 2100; i++) cyc(1'b1, 22'h3FFFFF);

    // R8: rest notes repeat the previous sample.
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1, '0);
      cyc(1'b0, '0);
    end

    // Pseudo-random steps.
    for (int i = 0; i < 3000; i++) begin
      cyc(1'b1, 22'((i * 7919 + 12345) & 22'h3FFFFF));
      if (i % 4 == 0) cyc(1'b0, '0);
    end

    // R1: reset while requests are in flight.
    cyc(1'b1, 22'd5000);
    cyc(1'b1, 22'd7000);
    rst = 1'b1;
    cyc(1'b0, '0);
    chk("R1", int'(sv), 0);
    chk("R1", int'(smp), 0);
    rst = 1'b0;
    cyc(1'b1, {12'd1000, 10'd0});
    repeat (4) cyc(1'b0, '0);
    chk("R1", int'(smp), ref_sample({12'd1000, 10'd0}));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule